// File: doc/BRIEF.md
# Multiplexed SAR ADC Conversion Sequencer

This block is the digital side of an eight-channel, eight-bit charge-redistribution converter. A 3-bit channel address is taken in on a rising edge of an address-load strobe and turned into a one-hot select for the analog input switches. A rising edge on the start input clears the output register, drops end-of-conversion and begins a fixed 32-clock sampling phase. During that phase the sample control is asserted and every bit capacitor charges to the input. The block then resolves the eight bits from weight 128 down to weight 1. Each bit gets four clocks, and the per-bit reference switches are driven on every step. In the last cycle the result is moved into the output register and end-of-conversion rises.

Start and address-load are each synchronized through two flip-flops, and their edges are found on the synchronized copies. A start edge at any point of a run aborts it and begins a fresh one. If end-of-conversion is fed back into start, the block converts continuously once a single external start pulse has been given after reset. The output register drives the data pins only while output enable is high.

FSM states: `ST_IDLE` (waiting), `ST_SAMPLE` (32 sampling clocks), `ST_SETTLE`, `ST_STROBE`, `ST_DECIDE` and `ST_GUARD` (the four clocks of one bit step), and `ST_LOAD` (result transfer).

Transitions:
- Any state goes to `ST_SAMPLE` on a detected start edge.
- `ST_SAMPLE` goes to `ST_SETTLE` after its 32nd clock.
- `ST_SETTLE` goes to `ST_STROBE`, then to `ST_DECIDE`, then to `ST_GUARD`.
- `ST_GUARD` goes back to `ST_SETTLE` for the next lower bit, or to `ST_LOAD` after bit 0.
- `ST_LOAD` goes to `ST_IDLE`.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset `ch_sel` is 8'h01. A rising edge of `addr_load` captures `addr_in`, with bit 2 as the most significant bit, and sets only `ch_sel[addr_in]`. The new select is visible after the third rising clock edge counted from the first edge that sees the strobe high. Changes of `addr_in` without a strobe leave `ch_sel` unchanged.
- R2: A start edge clears the output register to zero on the cycle its synchronized edge is acted on (third clock edge after `start` is first seen high).
- R3: `sample_en` is high for exactly 32 clocks, from the third edge after `start` is first seen high. `ref_pos` is all zeros while it is high.
- R4: `eoc` is low by the third clock edge after the start input rises (within 8 clocks), and stays low until the new result is loaded.
- R5: While bit k is under test, `ref_pos[k]` is 1 and all lower bits are 0. Each higher bit j is 0 if bit j was recorded as 1 and 1 otherwise.
- R6: A bit is recorded as 1 when `cmp_hi` is high in its decision cycle. With a comparator that reports input at or above the trial code, the loaded result equals the sampled input code.
- R7: `eoc` rises and the result appears in the output register on the 68th clock edge after `start` is first seen high, and not before.
- R8: A start edge during a run aborts it. Sampling restarts, the partial result is discarded, and the next result appears 68 edges after the new start.
- R9: `dout_oe` follows `out_en`. Toggling `out_en` does not change the held result.
- R10: With `eoc` looped back to `start`, nothing starts after reset until one external pulse is given. Conversions then repeat with one result every 68 clocks.
- R11: Each bit step lasts four clocks. Bit 7 is under test from edge 32 after the detected start, and bit 6 is not under test before edge 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | Channel address, MSB first |
| addr_load | input | 1 | Address-load strobe, rising edge captures |
| start | input | 1 | Start strobe, rising edge begins a conversion |
| cmp_hi | input | 1 | Comparator: summing node above trip point |
| out_en | input | 1 | Output enable for the data pins |
| ch_sel | output | 2**ADDR_W | One-hot analog input switch select |
| sample_en | output | 1 | Sample switches closed |
| ref_pos | output | DATA_W | Per-bit capacitor tied to positive reference (1) or negative (0) |
| eoc | output | 1 | End of conversion |
| dout | output | DATA_W | Latched result, high impedance when not enabled |
| dout_oe | output | 1 | Data pin drive enable |

## Verification
The assertions assume that `start` and `addr_load` pulses are held for at least one clock and are low for at least two clocks between pulses. They also assume that `addr_in` is stable from the strobe until the capture edge, and that `cmp_hi` settles within the cycle from the present `ref_pos` and selected channel. The bench meets these assumptions by driving every input on the falling clock edge, holding each strobe for exactly one clock and then waiting several more, and keeping the address until capture. It also derives `cmp_hi` combinationally from a model of the capacitor array, which rebuilds the trial code from `ref_pos` and the selected channel's input value. Random channel and code choices run through this same timing, and fixed extreme codes, aborts and the looped mode are added as directed cases.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SETTLE,
        ST_STROBE,
        ST_DECIDE,
        ST_GUARD,
        ST_LOAD
    } seq_state_t;

endpackage

// File: rtl/adcseq_edge_sync.sv
module adcseq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);

    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], d};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/adcseq_chan_select.sv
module adcseq_chan_select #(
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr,
    output logic [(1<<ADDR_W)-1:0]   sel
);

    localparam int NCH = 1 << ADDR_W;

    logic [ADDR_W-1:0] ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else if (load) begin
            ch_q <= addr;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign sel[g] = (ch_q == ADDR_W'(g));
    end

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cmp_hi,
    output logic              sample_en,
    output logic [DATA_W-1:0] ref_pos,
    output logic [DATA_W-1:0] result,
    output logic              load_now
);

    localparam int CW = $clog2(SAMPLE_CYC);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLE_CYC - 1);
    localparam logic [BW-1:0] BIT_TOP  = BW'(DATA_W - 1);

    seq_state_t        state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] rec_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (go) begin
            state_d = ST_SAMPLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SAMPLE: if (cnt_q == CNT_LAST) state_d = ST_SETTLE;
                ST_SETTLE: state_d = ST_STROBE;
                ST_STROBE: state_d = ST_DECIDE;
                ST_DECIDE: state_d = ST_GUARD;
                ST_GUARD:  state_d = (bit_q == '0) ? ST_LOAD : ST_SETTLE;
                ST_LOAD:   state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= BIT_TOP;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (go) begin
                cnt_q <= '0;
                bit_q <= BIT_TOP;
                rec_q <= '0;
            end else begin
                if (state_q == ST_SAMPLE) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (state_q == ST_DECIDE && cmp_hi) begin
                    rec_q[bit_q] <= 1'b1;
                end
                if (state_q == ST_GUARD && bit_q != '0) begin
                    bit_q <= bit_q - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        logic stepping;
        stepping  = (state_q == ST_SETTLE) || (state_q == ST_STROBE) ||
                    (state_q == ST_DECIDE) || (state_q == ST_GUARD);
        sample_en = (state_q == ST_SAMPLE);
        load_now  = (state_q == ST_LOAD) && !go;
        result    = rec_q;
        ref_pos   = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (stepping) begin
                if (i > int'(bit_q)) begin
                    ref_pos[i] = ~rec_q[i];
                end else if (i == int'(bit_q)) begin
                    ref_pos[i] = (state_q == ST_GUARD) ? ~rec_q[i] : 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SAMPLE_CYC  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_in,
    input  logic                   addr_load,
    input  logic                   start,
    input  logic                   cmp_hi,
    input  logic                   out_en,
    output logic [(1<<ADDR_W)-1:0] ch_sel,
    output logic                   sample_en,
    output logic [DATA_W-1:0]      ref_pos,
    output logic                   eoc,
    output logic [DATA_W-1:0]      dout,
    output logic                   dout_oe
);

    logic              go_pulse;
    logic              ale_pulse;
    logic              load_now;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] out_q;
    logic              eoc_q;

    adcseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (start),
        .rise (go_pulse)
    );

    adcseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ale (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (addr_load),
        .rise (ale_pulse)
    );

    adcseq_chan_select #(.ADDR_W(ADDR_W)) u_chan (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ale_pulse),
        .addr (addr_in),
        .sel  (ch_sel)
    );

    adcseq_fsm #(.DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_pulse),
        .cmp_hi   (cmp_hi),
        .sample_en(sample_en),
        .ref_pos  (ref_pos),
        .result   (result),
        .load_now (load_now)
    );

    // output register and end-of-conversion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            eoc_q <= 1'b0;
        end else if (go_pulse) begin
            out_q <= '0;
            eoc_q <= 1'b0;
        end else if (load_now) begin
            out_q <= result;
            eoc_q <= 1'b1;
        end
    end

    assign eoc     = eoc_q;
    assign dout    = out_en ? out_q : 'z;
    assign dout_oe = out_en;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   go,
    input logic                   sample_en,
    input logic [DATA_W-1:0]      ref_pos,
    input logic                   eoc,
    input logic [DATA_W-1:0]      latch,
    input logic [(1<<ADDR_W)-1:0] ch_sel
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_sel) == 1); // R1

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (latch == '0)); // R2

    AST_SAMPLE_REFS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (ref_pos == '0)); // R3

    AST_START_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !eoc); // R4

    AST_SAMPLE_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !eoc); // R4

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !go) |=> $stable(latch)); // R9

endmodule

bind adc_conv_sequencer adcseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_pulse),
    .sample_en(sample_en),
    .ref_pos  (ref_pos),
    .eoc      (eoc),
    .latch    (out_q),
    .ch_sel   (ch_sel)
);

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      addr_in = '0;
    logic            addr_load = 1'b0;
    logic            st_ext = 1'b0;
    logic            loop_mode = 1'b0;
    logic            out_en = 1'b1;
    logic            start;
    logic            cmp_hi;
    logic [NCH-1:0]  ch_sel;
    logic            sample_en;
    logic [7:0]      ref_pos;
    logic            eoc;
    logic [7:0]      dout;
    logic            dout_oe;
    logic [NCH-1:0][7:0] vin_bank = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign start = st_ext | (loop_mode & eoc);

    adc_conv_sequencer i_adc_conv_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (addr_in),
        .addr_load(addr_load),
        .start    (start),
        .cmp_hi   (cmp_hi),
        .out_en   (out_en),
        .ch_sel   (ch_sel),
        .sample_en(sample_en),
        .ref_pos  (ref_pos),
        .eoc      (eoc),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    // capacitor-array model: trial code rebuilt from the reference switches
    function automatic logic [7:0] trial_of(input logic [7:0] rp);
        logic [7:0] t;
        int k;
        k = -1;
        for (int i = 7; i >= 0; i--) if (rp[i]) k = i;
        t = '0;
        for (int i = 0; i < 8; i++) begin
            if (k >= 0 && i > k) t[i] = ~rp[i];
        end
        if (k >= 0) t[k] = 1'b1;
        return t;
    endfunction

    always_comb begin
        logic [7:0] sv;
        sv = '0;
        for (int i = 0; i < NCH; i++) if (ch_sel[i]) sv = vin_bank[i];
        cmp_hi = (sv >= trial_of(ref_pos));
    end

    function automatic logic [7:0] sar_ref(input logic [7:0] v);
        logic [7:0] acc;
        acc = '0;
        for (int b = 7; b >= 0; b--) begin
            if (v >= (acc | (8'd1 << b))) acc = acc | (8'd1 << b);
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_chan(input int ch);
        addr_in = 3'(ch);
        addr_load = 1'b1;
        edges(1);
        addr_load = 1'b0;
        edges(3);
    endtask

    task automatic pulse_start;
        st_ext = 1'b1;
        edges(1);
        st_ext = 1'b0;
    endtask

    task automatic run_quick(input int ch, input logic [7:0] v);
        vin_bank[ch] = v;
        set_chan(ch);
        check(ch_sel == NCH'(1 << ch), "R1 select", ch_sel, 1 << ch);
        pulse_start();
        edges(66);
        check(eoc == 1'b0, "R7 eoc early", eoc, 0);
        edges(1);
        check(eoc == 1'b1, "R7 eoc at 68", eoc, 1);
        check(dout == sar_ref(v), "R6 result", dout, sar_ref(v));
    endtask

    task automatic run_detailed(input int ch, input logic [7:0] v);
        vin_bank[ch] = v;
        set_chan(ch);
        check(ch_sel == NCH'(1 << ch), "R1 select", ch_sel, 1 << ch);
        pulse_start();
        edges(2);
        check(eoc == 1'b0, "R4 eoc low", eoc, 0);
        check(dout == 8'h00, "R2 cleared", dout, 0);
        check(sample_en == 1'b1, "R3 sample start", sample_en, 1);
        check(ref_pos == 8'h00, "R3 refs low", ref_pos, 0);
        edges(31);
        check(sample_en == 1'b1, "R3 sample last", sample_en, 1);
        edges(1);
        check(sample_en == 1'b0, "R3 sample end", sample_en, 0);
        check(ref_pos == 8'h80, "R11 bit7 trial", ref_pos, 8'h80);
        edges(3);
        check(ref_pos[6] == 1'b0, "R11 bit6 not yet", ref_pos[6], 0);
        edges(1);
        check(ref_pos == {~v[7], 1'b1, 6'b0}, "R5 bit6 trial", ref_pos, {~v[7], 1'b1, 6'b0});
        edges(28);
        check(eoc == 1'b0, "R4 eoc held low", eoc, 0);
        edges(1);
        check(eoc == 1'b1, "R7 eoc rise", eoc, 1);
        check(dout == v, "R6 result", dout, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'd20240);
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // reset state
        check(ch_sel == 8'h01, "R1 reset select", ch_sel, 1);
        check(eoc == 1'b0, "R4 reset eoc", eoc, 0);
        check(sample_en == 1'b0, "R3 reset sample", sample_en, 0);
        check(dout == 8'h00, "R2 reset data", dout, 0);

        // continuous mode needs an external first pulse
        loop_mode = 1'b1;
        vin_bank[0] = 8'h5A;
        edges(20);
        check(eoc == 1'b0 && sample_en == 1'b0, "R10 no self start", eoc, 0);
        pulse_start();
        edges(67);
        check(eoc == 1'b1, "R10 first loop eoc", eoc, 1);
        check(dout == 8'h5A, "R10 first loop data", dout, 8'h5A);
        vin_bank[0] = 8'hC3;
        edges(68);
        check(eoc == 1'b1, "R10 second loop eoc", eoc, 1);
        check(dout == 8'hC3, "R10 second loop data", dout, 8'hC3);
        loop_mode = 1'b0;
        edges(5);

        // directed corner codes
        run_detailed(1, 8'h00);
        run_detailed(4, 8'hFF);
        run_detailed(6, 8'h80);
        run_detailed(7, 8'h7F);
        run_detailed(3, 8'hA6);

        // address change without strobe is ignored (R1)
        set_chan(5);
        addr_in = 3'b010;
        edges(5);
        check(ch_sel == 8'h20, "R1 no strobe", ch_sel, 8'h20);

        // output enable (R9)
        vin_bank[5] = 8'h39;
        run_quick(5, 8'h39);
        out_en = 1'b0;
        edges(2);
        check(dout_oe == 1'b0, "R9 drive off", dout_oe, 0);
        out_en = 1'b1;
        edges(1);
        check(dout_oe == 1'b1, "R9 drive on", dout_oe, 1);
        check(dout == 8'h39, "R9 held", dout, 8'h39);

        // abort and restart (R8)
        vin_bank[2] = 8'h3C;
        set_chan(2);
        pulse_start();
        edges(40);
        vin_bank[2] = 8'hA5;
        pulse_start();
        edges(2);
        check(sample_en == 1'b1, "R8 resample", sample_en, 1);
        check(dout == 8'h00, "R2 abort clear", dout, 0);
        edges(64);
        check(eoc == 1'b0, "R8 eoc low", eoc, 0);
        edges(1);
        check(eoc == 1'b1, "R8 eoc rise", eoc, 1);
        check(dout == 8'hA5, "R8 new result", dout, 8'hA5);

        // random conversions
        for (int n = 0; n < 24; n++) begin
            int ch;
            logic [7:0] v;
            ch = int'($urandom % NCH);
            v = 8'($urandom);
            for (int c = 0; c < NCH; c++) vin_bank[c] = 8'($urandom);
            run_quick(ch, v);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule